// File: doc/BRIEF.md
# Footprint-Predicted Page Fill Engine

This block drives the fill side of a DRAM cache that allocates whole 4 KB pages but pulls in only some of each page's 64-byte blocks. When a page miss arrives, the block looks up a direct-mapped, tagged history table. The table is keyed by the PC of the missing instruction and the block offset that missed. The stored 64-bit footprint says which blocks of the page are expected to be used. The engine then issues one off-chip block request per cycle for those blocks. The block that missed is always requested, and it goes first.

When the cache evicts a page, it reports the key that opened that page and the vector of blocks that were actually touched. The engine writes that vector into the table entry for the key, replacing any previous contents. A later miss with the same key fetches exactly that set of blocks. Tags, data storage and the replacement choice stay outside this block.

Top module: `fp_fill_engine`

## Requirements
- R1: After reset `miss_ready` is 1, `fetch_valid` is 0, and every table entry is invalid, so any miss fetches only the block that missed.
- R2: A miss whose table entry is invalid, or whose stored tag differs from {PC, block offset}, issues exactly one request, for the missing block.
- R3: The missing block is always requested, even when the stored footprint has its bit clear.
- R4: The missing block is requested first. The remaining predicted blocks follow in ascending block number.
- R5: Requests are issued on consecutive cycles, one per cycle. The first request is visible two clock edges after the miss is accepted.
- R6: The request address is {page number from miss_addr[31:12], block number, 6'b0}. The block offset of a miss is miss_addr[11:6].
- R7: `miss_ready` falls on the edge that accepts a miss and returns to 1 on the edge after the last request. While it is 0, `miss_valid` is ignored.
- R8: An eviction writes entry index = evict_pc[5:0] XOR evict_off, with tag {evict_pc, evict_off} and footprint `evict_used`, replacing the old entry. A later miss with the same key requests exactly `evict_used` plus the missing block.
- R9: If an eviction and an accepted miss fall in the same cycle and map to the same index, the lookup sees the newly written entry.
- R10: Two keys that share an index evict each other. After the second key is trained, a miss with the first key falls back to R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Page miss present |
| miss_addr | input | 32 | Byte address of the missing access |
| miss_pc | input | 32 | PC of the missing instruction |
| miss_ready | output | 1 | Engine idle and able to accept a miss |
| fetch_valid | output | 1 | Off-chip block request valid |
| fetch_addr | output | 32 | Block-aligned byte address to fetch |
| evict_valid | input | 1 | Page eviction report present |
| evict_pc | input | 32 | PC of the key that opened the evicted page |
| evict_off | input | 6 | Block offset of that key |
| evict_used | input | 64 | Blocks touched while the page was resident |

## Verification
Training from an eviction and the lookup for a new miss can happen in the same clock edge and hit the same table index. That race is the hazard this engine has to resolve. The bench provokes it by raising `evict_valid` and `miss_valid` together with matching keys. It then requires the request stream to follow the footprint just written, not the stale one. A same-index, different-tag variant and randomly mixed eviction and miss traffic are checked against a bench-side table model that applies each eviction before it forms the miss's expected request list.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_ISSUE  = 2'd2
  } fp_state_e;
endpackage

// File: rtl/fp_lowbit.sv
module fp_lowbit #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/fp_table.sv
module fp_table #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 38,
  parameter int VEC_W   = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ROW_W  = TAG_W + VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [VEC_W-1:0] rd_vec
);
  logic [ROW_W-1:0]   mem [ENTRIES];
  logic [ROW_W-1:0]   rd_q;
  logic [ROW_W-1:0]   byp_q;
  logic               byp_sel_q;
  logic               rd_valid_q;
  logic [ENTRIES-1:0] valid_q;

  // Row storage: no reset, single write port, registered read.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_vec};
    if (rd_en) rd_q <= mem[rd_idx];
  end

  // Valid bits and forwarding of a same-cycle write to the read.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      byp_sel_q  <= 1'b0;
      byp_q      <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      if (rd_en) begin
        byp_sel_q  <= wr_en && (wr_idx == rd_idx);
        byp_q      <= {wr_tag, wr_vec};
        rd_valid_q <= valid_q[rd_idx] || (wr_en && (wr_idx == rd_idx));
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign {rd_tag, rd_vec} = byp_sel_q ? byp_q : rd_q;

  // R8: a training write leaves its entry valid.
  assert_train_sets_valid_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/fp_seq.sv
module fp_seq
  import fp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 32,
  parameter int PAGE_SH = 12,
  parameter int BLK_SH  = 6,
  localparam int OFF_W  = PAGE_SH - BLK_SH,
  localparam int NBLK   = 1 << OFF_W,
  localparam int PG_W   = ADDR_W - PAGE_SH,
  localparam int TAG_W  = PC_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [PG_W-1:0]   miss_page,
  input  logic [OFF_W-1:0]  miss_off,
  input  logic [PC_W-1:0]   miss_pc,
  output logic              miss_ready,
  output logic              accept,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [NBLK-1:0]   rd_vec,
  output logic [NBLK-1:0]   pend,
  input  logic [OFF_W-1:0]  low_idx,
  input  logic              low_any,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr
);
  fp_state_e         state_q;
  logic [PG_W-1:0]   page_q;
  logic [OFF_W-1:0]  trig_q;
  logic [TAG_W-1:0]  tag_q;
  logic [NBLK-1:0]   pend_q;
  logic [OFF_W-1:0]  blk_q;
  logic              first_q;
  logic              hit;

  assign accept = miss_valid && miss_ready;
  assign hit    = rd_valid && (rd_tag == tag_q);
  assign pend   = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      miss_ready  <= 1'b1;
      fetch_valid <= 1'b0;
      page_q      <= '0;
      trig_q      <= '0;
      tag_q       <= '0;
      pend_q      <= '0;
      blk_q       <= '0;
      first_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          page_q     <= miss_page;
          trig_q     <= miss_off;
          tag_q      <= {miss_pc, miss_off};
          miss_ready <= 1'b0;
          state_q    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          pend_q      <= (hit ? rd_vec : '0) & ~(NBLK'(1) << trig_q);
          fetch_valid <= 1'b1;
          blk_q       <= trig_q;
          first_q     <= 1'b1;
          state_q     <= ST_ISSUE;
        end
        ST_ISSUE: begin
          first_q <= 1'b0;
          if (low_any) begin
            blk_q           <= low_idx;
            pend_q[low_idx] <= 1'b0;
          end else begin
            fetch_valid <= 1'b0;
            miss_ready  <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_addr = {page_q, blk_q, {BLK_SH{1'b0}}};

  // R7: no request while idle, and acceptance drops ready at once.
  assert_busy_while_fetching_R7: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> !miss_ready);
  assert_accept_drops_ready_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> !miss_ready);
  // R3: the request after the lookup cycle is the missing block.
  assert_trigger_first_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP) |=> (fetch_valid && blk_q == $past(trig_q)));
  // R4: after the first request, block numbers strictly rise.
  assert_ascending_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !first_q && $past(fetch_valid) && !$past(first_q))
      |-> (blk_q > $past(blk_q)));
endmodule

// File: rtl/fp_fill_engine.sv
module fp_fill_engine #(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int BLK_BYTES  = 64,
  parameter int ENTRIES    = 64,
  localparam int PAGE_SH   = $clog2(PAGE_BYTES),
  localparam int BLK_SH    = $clog2(BLK_BYTES),
  localparam int OFF_W     = PAGE_SH - BLK_SH,
  localparam int NBLK      = 1 << OFF_W,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int TAG_W     = PC_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [PC_W-1:0]   miss_pc,
  output logic              miss_ready,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              evict_valid,
  input  logic [PC_W-1:0]   evict_pc,
  input  logic [OFF_W-1:0]  evict_off,
  input  logic [NBLK-1:0]   evict_used
);
  logic [OFF_W-1:0] miss_off;
  logic             accept;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [NBLK-1:0]  rd_vec;
  logic [NBLK-1:0]  pend;
  logic [OFF_W-1:0] low_idx;
  logic             low_any;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;

  assign miss_off = miss_addr[PAGE_SH-1:BLK_SH];
  assign rd_idx   = miss_pc[IDX_W-1:0] ^ IDX_W'(miss_off);
  assign wr_idx   = evict_pc[IDX_W-1:0] ^ IDX_W'(evict_off);

  fp_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .VEC_W(NBLK)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(evict_valid), .wr_idx(wr_idx), .wr_tag({evict_pc, evict_off}), .wr_vec(evict_used),
    .rd_en(accept), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_vec(rd_vec)
  );

  fp_lowbit #(.N(NBLK), .W(OFF_W)) u_low (
    .vec(pend), .idx(low_idx), .any(low_any)
  );

  fp_seq #(.ADDR_W(ADDR_W), .PC_W(PC_W), .PAGE_SH(PAGE_SH), .BLK_SH(BLK_SH)) u_seq (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_page(miss_addr[ADDR_W-1:PAGE_SH]),
    .miss_off(miss_off), .miss_pc(miss_pc),
    .miss_ready(miss_ready), .accept(accept),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_vec(rd_vec),
    .pend(pend), .low_idx(low_idx), .low_any(low_any),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr)
  );
endmodule

// File: tb/fp_fill_engine_bench.sv
module fp_fill_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic [31:0] miss_pc = '0;
  logic        miss_ready;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        evict_valid = 1'b0;
  logic [31:0] evict_pc = '0;
  logic [5:0]  evict_off = '0;
  logic [63:0] evict_used = '0;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  bit          m_v   [64];
  logic [37:0] m_tag [64];
  logic [63:0] m_vec [64];
  logic [31:0] exp_a [64];
  int          exp_n;

  always #10 clk = ~clk;

  fp_fill_engine u_fp_fill_engine (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_pc(miss_pc),
    .miss_ready(miss_ready), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .evict_valid(evict_valid), .evict_pc(evict_pc), .evict_off(evict_off),
    .evict_used(evict_used)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_train(input logic [31:0] pc, input logic [5:0] off, input logic [63:0] used);
    int idx = int'(pc[5:0] ^ off);
    m_v[idx] = 1'b1;
    m_tag[idx] = {pc, off};
    m_vec[idx] = used;
  endtask

  task automatic build_exp(input logic [31:0] addr, input logic [31:0] pc);
    logic [5:0]  off = addr[11:6];
    int          idx = int'(pc[5:0] ^ off);
    logic [63:0] v = (m_v[idx] && m_tag[idx] == {pc, off}) ? m_vec[idx] : 64'd0;
    exp_n = 1;
    exp_a[0] = {addr[31:12], off, 6'b0};
    for (int b = 0; b < 64; b++) begin
      if (v[b] && b != int'(off)) begin
        exp_a[exp_n] = {addr[31:12], 6'(b), 6'b0};
        exp_n++;
      end
    end
  endtask

  task automatic do_evict(input logic [31:0] pc, input logic [5:0] off, input logic [63:0] used);
    evict_valid = 1'b1; evict_pc = pc; evict_off = off; evict_used = used;
    model_train(pc, off, used);
    @(negedge clk);
    evict_valid = 1'b0;
  endtask

  // Issues one miss, optionally with a same-cycle eviction and/or miss_valid
  // held high while busy, and compares the request stream.
  task automatic do_miss(input logic [31:0] addr, input logic [31:0] pc,
                         input bit with_ev, input logic [31:0] epc,
                         input logic [5:0] eoff, input logic [63:0] eused,
                         input bit spam, input string req);
    logic [31:0] got [64];
    int n = 0;
    int first_k = -1;
    int last_k = -1;
    bool_done: begin end
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1; miss_addr = addr; miss_pc = pc;
    if (with_ev) begin
      evict_valid = 1'b1; evict_pc = epc; evict_off = eoff; evict_used = eused;
      model_train(epc, eoff, eused);
    end
    build_exp(addr, pc);
    @(negedge clk);
    evict_valid = 1'b0;
    if (spam) begin
      miss_addr = addr ^ 32'h0005_5000;
      miss_pc = pc ^ 32'h3;
    end else miss_valid = 1'b0;
    check(miss_ready == 1'b0, "R7 ready low after accept", 64'(miss_ready), 64'd0);
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (fetch_valid) begin
        if (n < 64) got[n] = fetch_addr;
        if (first_k < 0) first_k = k;
        last_k = k;
        n++;
      end
      if (miss_ready) begin
        miss_valid = 1'b0;
        break;
      end
    end
    check(n == exp_n, {req, " request count"}, 64'(n), 64'(exp_n));
    check(first_k == 1, "R5 first request latency", 64'(first_k), 64'd1);
    check(last_k - first_k + 1 == n, "R5 back-to-back", 64'(last_k - first_k + 1), 64'(n));
    for (int i = 0; i < n && i < exp_n; i++) begin
      check(got[i] == exp_a[i], {req, " R4 R6 request address"}, 64'(got[i]), 64'(exp_a[i]));
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_vec[i] = '0; end
  end

  initial begin : watchdog
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [31:0] pa = 32'h0000_1230;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(miss_ready == 1'b1, "R1 ready after reset", 64'(miss_ready), 64'd1);
    check(fetch_valid == 1'b0, "R1 no request after reset", 64'(fetch_valid), 64'd0);

    // R1 R2: empty table, single request
    do_miss(32'h1234_5140, pa, 0, 0, 0, 0, 0, "R1 R2 untrained");
    // R8: train then hit with a different page
    do_evict(pa, 6'd5, (64'd1 << 0) | (64'd1 << 3) | (64'd1 << 5) | (64'd1 << 63));
    do_miss(32'h0ABC_D140, pa, 0, 0, 0, 0, 0, "R8 trained hit");
    // R3: stored footprint lacks the missing block
    do_evict(32'h0000_7700, 6'd10, (64'd1 << 2) | (64'd1 << 4));
    do_miss(32'h0000_0280, 32'h0000_7700, 0, 0, 0, 0, 0, "R3 forced trigger");
    // R10: same index, other key
    do_evict(pa ^ 32'h1, 6'd4, 64'd2);
    do_miss(32'h0000_3140, pa, 0, 0, 0, 0, 0, "R10 displaced key");
    do_miss(32'h0000_3100, pa ^ 32'h1, 0, 0, 0, 0, 0, "R10 new key");
    // R9: eviction in the accepting cycle, same key
    do_miss(32'h0000_51C0, 32'h0000_9900, 1, 32'h0000_9900, 6'd7, 64'h380, 0, "R9 same-cycle train");
    // R9: same cycle, same index, different tag
    do_miss(32'h0000_61C0, 32'h0000_9900, 1, 32'h0000_9901, 6'd6, 64'hFF, 0, "R9 same-cycle conflict");
    // R7: full footprint with miss_valid held during the burst
    do_evict(32'h0000_AA00, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    do_miss(32'h0000_8000, 32'h0000_AA00, 0, 0, 0, 0, 1, "R7 busy ignores misses");
    @(negedge clk);
    check(fetch_valid == 1'b0, "R7 no extra request", 64'(fetch_valid), 64'd0);
    check(miss_ready == 1'b1, "R7 ready stays high", 64'(miss_ready), 64'd1);
    // R4: last block as trigger with lower blocks predicted
    do_evict(32'h0000_BB00, 6'd63, 64'h8000_0000_0000_0011);
    do_miss(32'h0000_9FC0, 32'h0000_BB00, 0, 0, 0, 0, 0, "R4 top trigger");

    // Random mix of training and misses over a small key pool
    for (int it = 0; it < 80; it++) begin
      logic [31:0] rpc = 32'h0000_4000 | 32'($urandom_range(0, 7));
      logic [5:0]  roff = 6'($urandom_range(0, 3));
      logic [63:0] ru = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      int sel = $urandom_range(0, 2);
      if (sel == 0) do_evict(rpc, roff, ru);
      else if (sel == 1)
        do_miss({12'($urandom()), 8'h00, roff, 6'h00}, rpc, 0, 0, 0, 0, 0, "R8 random");
      else
        do_miss({12'($urandom()), 8'h00, roff, 6'h00}, rpc, 1,
                32'h0000_4000 | 32'($urandom_range(0, 7)), 6'($urandom_range(0, 3)), ru, 0,
                "R9 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule